// File: doc/BRIEF.md
# Resolver Gain and Phase Corrector

This block sits between the resolver front end and the angle tracker. It takes a stream of 16-bit signed sine and cosine samples. Each channel is scaled by an unsigned fixed-point gain. The cosine channel then gets a signed fraction of the scaled sine mixed into it, which pulls the two channels back to a 90° relationship. The result leaves as a saturated 16-bit pair, two clock cycles after the sample entered.

The coefficients come from one of two places: an estimator interface or a set of manual override inputs. Automatic correction can only be used while estimation is switched on. Within that, it is either gain-only or gain-plus-phase. When automatic gain is off, the manual gains apply. When automatic phase is not active, the manual phase applies. Estimator gains map the signal to full scale, so a small right shift can be set to trade amplitude for headroom against clipping.

The stream is qualified by a valid bit only and has no back-pressure. The block accepts a sample on every cycle in which `in_valid` is high. The sink must take every `out_valid` beat, because nothing can stall the pipeline.

Top module: `gain_phase_corrector`

## Requirements
- R1: Gains are unsigned with 14 fraction bits: a gain of 16384 passes a sample through unchanged, and in general the scaled value is x·g/2^14 rounded half up.
- R2: When `est_enable` is 0 or `auto_gain_en` is 0, the manual gains `man_gain_sin`/`man_gain_cos` are used and the estimator gains have no effect.
- R3: When `est_enable` and `auto_gain_en` are both 1, the estimator gains are used, each shifted right by `headroom_shift` (0 to 3) before being applied.
- R4: The estimator phase is used only when `est_enable`, `auto_gain_en` and `auto_phase_en` are all 1; otherwise `man_phase` is used.
- R5: `out_sin` is the scaled sine. `out_cos` is the scaled cosine plus (scaled sine × phase)/2^15 rounded half up, where the phase is signed and +32767 is close to +1.0 (about +90°).
- R6: Both outputs saturate to the range -32768 to 32767 and never wrap, both after the gain and after the phase mix.
- R7: `out_valid` is high exactly two cycles after each `in_valid` beat, back-to-back beats stream at one per cycle, and output data holds its value while `out_valid` is low.
- R8: The coefficients are captured together with their sample, so control changes made while a sample is in flight do not affect that sample.
- R9: While `rst_n` is low, `out_valid`, `out_sin` and `out_cos` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_sin | input | 16 | Signed sine sample |
| in_cos | input | 16 | Signed cosine sample |
| est_enable | input | 1 | Estimator running; required for any automatic correction |
| auto_gain_en | input | 1 | Use estimator gains |
| auto_phase_en | input | 1 | Use estimator phase (needs auto gain) |
| headroom_shift | input | 2 | Right shift applied to estimator gains |
| est_gain_sin | input | 16 | Estimator sine gain, unsigned Q2.14 |
| est_gain_cos | input | 16 | Estimator cosine gain, unsigned Q2.14 |
| est_phase | input | 16 | Estimator phase, signed Q1.15 |
| man_gain_sin | input | 16 | Manual sine gain, unsigned Q2.14 |
| man_gain_cos | input | 16 | Manual cosine gain, unsigned Q2.14 |
| man_phase | input | 16 | Manual phase, signed Q1.15 |
| out_valid | output | 1 | Output sample strobe |
| out_sin | output | 16 | Corrected sine |
| out_cos | output | 16 | Corrected cosine |

## Verification
A sample presented before a rising edge is captured with its coefficients at that edge. It appears on the outputs after the following edge, so every corrected result is due two rising edges after its `in_valid` beat. The bench drives inputs and samples outputs on falling edges. It reads each result at the falling edge after the second rising edge and checks that `out_valid` is low one edge earlier and one edge later. For control changes and streaming, it checks the result of each beat in the cycle that beat is due. Reset values are read while reset is still asserted.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

  typedef enum logic [1:0] {
    SRC_MANUAL    = 2'd0,
    SRC_GAIN_AUTO = 2'd1,
    SRC_FULL_AUTO = 2'd2
  } coef_src_e;

  // Clamp a wide signed value into a w-bit signed range.
  function automatic longint sat_val(input longint v, input int unsigned w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -(longint'(1) <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/gpc_coef_sel.sv
module gpc_coef_sel
  import gpc_pkg::*;
#(
  parameter int COEF_W = 16,
  parameter int SHIFT_W = 2
) (
  input  logic              est_enable,
  input  logic              auto_gain_en,
  input  logic              auto_phase_en,
  input  logic [SHIFT_W-1:0] headroom_shift,
  input  logic [COEF_W-1:0] est_gain_sin,
  input  logic [COEF_W-1:0] est_gain_cos,
  input  logic [COEF_W-1:0] est_phase,
  input  logic [COEF_W-1:0] man_gain_sin,
  input  logic [COEF_W-1:0] man_gain_cos,
  input  logic [COEF_W-1:0] man_phase,
  output logic [COEF_W-1:0] sel_gain_sin,
  output logic [COEF_W-1:0] sel_gain_cos,
  output logic [COEF_W-1:0] sel_phase
);

  coef_src_e src;

  always_comb begin
    if (!est_enable || !auto_gain_en) src = SRC_MANUAL;
    else if (auto_phase_en)           src = SRC_FULL_AUTO;
    else                              src = SRC_GAIN_AUTO;
  end

  always_comb begin
    sel_gain_sin = man_gain_sin;
    sel_gain_cos = man_gain_cos;
    sel_phase    = man_phase;
    unique case (src)
      SRC_GAIN_AUTO: begin
        sel_gain_sin = est_gain_sin >> headroom_shift;
        sel_gain_cos = est_gain_cos >> headroom_shift;
      end
      SRC_FULL_AUTO: begin
        sel_gain_sin = est_gain_sin >> headroom_shift;
        sel_gain_cos = est_gain_cos >> headroom_shift;
        sel_phase    = est_phase;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/gpc_gain_lane.sv
module gpc_gain_lane
  import gpc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int GAIN_FRAC = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] sample,
  input  logic [COEF_W-1:0]        gain,
  output logic signed [DATA_W-1:0] scaled
);

  localparam int PW = DATA_W + COEF_W + 1;
  localparam logic signed [PW-1:0] HALF = PW'(longint'(1) <<< (GAIN_FRAC - 1));
  localparam logic [COEF_W-1:0] UNITY = COEF_W'(longint'(1) <<< GAIN_FRAC);

  logic signed [PW-1:0] prod_w;
  logic signed [PW-1:0] shifted_w;

  assign prod_w    = PW'(sample) * PW'($signed({1'b0, gain}));
  assign shifted_w = (prod_w + HALF) >>> GAIN_FRAC;

  always_ff @(posedge clk) begin
    if (!rst_n)        scaled <= '0;
    else if (in_valid) scaled <= DATA_W'(sat_val(longint'(shifted_w), DATA_W));
  end

  // R1: unity gain leaves the sample untouched
  assert_unity_gain_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && gain == UNITY) |=> scaled == $past(sample));

  // R7: the lane holds its value between beats
  assert_lane_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(scaled));

endmodule

// File: rtl/gpc_phase_mix.sv
module gpc_phase_mix
  import gpc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int PHASE_FRAC = 15
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] sin_g,
  input  logic signed [DATA_W-1:0] cos_g,
  input  logic signed [COEF_W-1:0] phase,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_sin,
  output logic signed [DATA_W-1:0] out_cos
);

  localparam int MW = DATA_W + COEF_W;
  localparam logic signed [MW-1:0] HALF = MW'(longint'(1) <<< (PHASE_FRAC - 1));
  localparam logic signed [DATA_W-1:0] SMAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] SMIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [MW-1:0] mix_w;
  logic signed [MW-1:0] mix_sh;
  longint               sum_l;

  assign mix_w  = MW'(sin_g) * MW'(phase);
  assign mix_sh = (mix_w + HALF) >>> PHASE_FRAC;
  assign sum_l  = longint'(cos_g) + longint'(mix_sh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sin   <= '0;
      out_cos   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sin <= sin_g;
        out_cos <= DATA_W'(sat_val(sum_l, DATA_W));
      end
    end
  end

  // R6: overflowing mix clamps at the rails
  assert_clip_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sum_l > longint'(SMAX)) |=> out_cos == SMAX);
  assert_clip_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sum_l < longint'(SMIN)) |=> out_cos == SMIN);

  // R7: one stage of latency here, data held between beats
  assert_stage_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_stage_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_cos) && $stable(out_sin)));

endmodule

// File: rtl/gain_phase_corrector.sv
module gain_phase_corrector
  import gpc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int GAIN_FRAC = 14,
  parameter int PHASE_FRAC = 15,
  parameter int SHIFT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sin,
  input  logic signed [DATA_W-1:0] in_cos,
  input  logic                     est_enable,
  input  logic                     auto_gain_en,
  input  logic                     auto_phase_en,
  input  logic [SHIFT_W-1:0]       headroom_shift,
  input  logic [COEF_W-1:0]        est_gain_sin,
  input  logic [COEF_W-1:0]        est_gain_cos,
  input  logic [COEF_W-1:0]        est_phase,
  input  logic [COEF_W-1:0]        man_gain_sin,
  input  logic [COEF_W-1:0]        man_gain_cos,
  input  logic [COEF_W-1:0]        man_phase,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_sin,
  output logic signed [DATA_W-1:0] out_cos
);

  localparam int NCH = 2;  // lane 0 = sine, lane 1 = cosine

  logic [COEF_W-1:0]        sel_gain_sin, sel_gain_cos, sel_phase;
  logic signed [DATA_W-1:0] lane_in  [NCH];
  logic [COEF_W-1:0]        lane_g   [NCH];
  logic signed [DATA_W-1:0] lane_out [NCH];
  logic                     s1_valid;
  logic signed [COEF_W-1:0] s1_phase;

  gpc_coef_sel #(.COEF_W(COEF_W), .SHIFT_W(SHIFT_W)) i_sel (
    .est_enable    (est_enable),
    .auto_gain_en  (auto_gain_en),
    .auto_phase_en (auto_phase_en),
    .headroom_shift(headroom_shift),
    .est_gain_sin  (est_gain_sin),
    .est_gain_cos  (est_gain_cos),
    .est_phase     (est_phase),
    .man_gain_sin  (man_gain_sin),
    .man_gain_cos  (man_gain_cos),
    .man_phase     (man_phase),
    .sel_gain_sin  (sel_gain_sin),
    .sel_gain_cos  (sel_gain_cos),
    .sel_phase     (sel_phase)
  );

  assign lane_in[0] = in_sin;
  assign lane_in[1] = in_cos;
  assign lane_g[0]  = sel_gain_sin;
  assign lane_g[1]  = sel_gain_cos;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    gpc_gain_lane #(.DATA_W(DATA_W), .COEF_W(COEF_W), .GAIN_FRAC(GAIN_FRAC)) i_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_valid(in_valid),
      .sample  (lane_in[ch]),
      .gain    (lane_g[ch]),
      .scaled  (lane_out[ch])
    );
  end

  // Phase coefficient travels with its sample
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_phase <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) s1_phase <= $signed(sel_phase);
    end
  end

  gpc_phase_mix #(.DATA_W(DATA_W), .COEF_W(COEF_W), .PHASE_FRAC(PHASE_FRAC)) i_mix (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (s1_valid),
    .sin_g    (lane_out[0]),
    .cos_g    (lane_out[1]),
    .phase    (s1_phase),
    .out_valid(out_valid),
    .out_sin  (out_sin),
    .out_cos  (out_cos)
  );

  // R4: manual phase whenever full automatic mode is not selected
  assert_manual_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(est_enable && auto_gain_en && auto_phase_en))
      |=> s1_phase == $signed($past(man_phase)));

  // R8: captured phase cannot move between beats
  assert_coef_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(s1_phase));

  // R9: nothing valid while reset is held
  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_sin == '0 && out_cos == '0));

endmodule

// File: tb/test_gain_phase_corrector.sv
module test_gain_phase_corrector;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic signed [15:0] s;
    logic signed [15:0] c;
    logic               en;
    logic               ag;
    logic               ap;
    logic [1:0]         sh;
    logic [15:0]        egs;
    logic [15:0]        egc;
    logic [15:0]        eph;
    logic [15:0]        mgs;
    logic [15:0]        mgc;
    logic [15:0]        mph;
  } vec_t;

  localparam int NV = 10;
  // s, c, en, ag, ap, sh, est_gs, est_gc, est_ph, man_gs, man_gc, man_ph
  localparam vec_t VECS [NV] = '{
    '{16'sd1000, -16'sd2000, 1'b0, 1'b0, 1'b0, 2'd0, 16'd0, 16'd0, 16'd0, 16'd16384, 16'd16384, 16'd0},          // R1 unity
    '{16'sd3001, -16'sd1001, 1'b0, 1'b0, 1'b0, 2'd0, 16'd0, 16'd0, 16'd0, 16'd8192, 16'd32768, 16'd0},            // R1 half/double, round
    '{16'sd1234, 16'sd4321, 1'b1, 1'b0, 1'b1, 2'd0, 16'd32768, 16'd32768, 16'd9000, 16'd16384, 16'd16384, 16'd0},// R2 auto gain off
    '{16'sd10000, 16'sd10000, 1'b1, 1'b1, 1'b0, 2'd0, 16'd20000, 16'd12000, 16'd5000, 16'd0, 16'd0, 16'd8192},   // R3 gain-only
    '{16'sd8000, -16'sd6000, 1'b1, 1'b1, 1'b1, 2'd0, 16'd16384, 16'd18000, 16'hF000, 16'd0, 16'd0, 16'd16000},   // R4 full auto
    '{16'sd7000, 16'sd3000, 1'b1, 1'b0, 1'b1, 2'd0, 16'd16384, 16'd16384, 16'd12000, 16'd16384, 16'd16384, 16'hE000}, // R4 phase needs gain
    '{-16'sd12000, 16'sd9999, 1'b1, 1'b1, 1'b0, 2'd2, 16'd65535, 16'd40000, 16'd0, 16'd0, 16'd0, 16'd0},         // R3 headroom
    '{16'sd30000, -16'sd30000, 1'b0, 1'b0, 1'b0, 2'd0, 16'd0, 16'd0, 16'd0, 16'd32768, 16'd32768, 16'd0},        // R6 gain clip
    '{16'sd32767, 16'sd32767, 1'b0, 1'b0, 1'b0, 2'd0, 16'd0, 16'd0, 16'd0, 16'd16384, 16'd16384, 16'd32767},     // R6 mix clip
    '{16'sd500, -16'sd700, 1'b0, 1'b1, 1'b1, 2'd3, 16'd50000, 16'd50000, 16'd20000, 16'd20000, 16'd24000, 16'd4000} // R2 R4 estimator off
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_sin = '0, in_cos = '0;
  logic est_enable = 1'b0, auto_gain_en = 1'b0, auto_phase_en = 1'b0;
  logic [1:0] headroom_shift = '0;
  logic [15:0] est_gain_sin = '0, est_gain_cos = '0, est_phase = '0;
  logic [15:0] man_gain_sin = '0, man_gain_cos = '0, man_phase = '0;
  logic out_valid;
  logic signed [15:0] out_sin, out_cos;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gain_phase_corrector i_gain_phase_corrector (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sin(in_sin), .in_cos(in_cos),
    .est_enable(est_enable), .auto_gain_en(auto_gain_en), .auto_phase_en(auto_phase_en),
    .headroom_shift(headroom_shift), .est_gain_sin(est_gain_sin), .est_gain_cos(est_gain_cos),
    .est_phase(est_phase), .man_gain_sin(man_gain_sin), .man_gain_cos(man_gain_cos),
    .man_phase(man_phase), .out_valid(out_valid), .out_sin(out_sin), .out_cos(out_cos)
  );

  function automatic longint clip16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // Expected results from the requirement text
  function automatic void model(input vec_t v, output longint es, output longint ec);
    bit gauto, pauto;
    longint gs, gc, ph, sg, cg;
    gauto = v.en && v.ag;
    pauto = gauto && v.ap;
    gs = gauto ? longint'(v.egs >> v.sh) : longint'(v.mgs);
    gc = gauto ? longint'(v.egc >> v.sh) : longint'(v.mgc);
    ph = pauto ? longint'($signed(v.eph)) : longint'($signed(v.mph));
    sg = clip16((longint'(v.s) * gs + 8192) >>> 14);
    cg = clip16((longint'(v.c) * gc + 8192) >>> 14);
    es = sg;
    ec = clip16(cg + ((sg * ph + 16384) >>> 15));
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    in_sin = v.s; in_cos = v.c;
    est_enable = v.en; auto_gain_en = v.ag; auto_phase_en = v.ap;
    headroom_shift = v.sh;
    est_gain_sin = v.egs; est_gain_cos = v.egc; est_phase = v.eph;
    man_gain_sin = v.mgs; man_gain_cos = v.mgc; man_phase = v.mph;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    longint es, ec;
    vec_t v;
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 valid", out_valid, 0);
    check("R9 sin", out_sin, 0);
    check("R9 cos", out_cos, 0);
    rst_n = 1'b1;

    // Vector table, one isolated beat each; R7 timing checked per beat
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VECS[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R7 not early", out_valid, 0);
      @(negedge clk);
      model(VECS[i], es, ec);
      check("R7 due", out_valid, 1);
      check($sformatf("R5 sin vec %0d", i), out_sin, es);
      check($sformatf("R5 cos vec %0d", i), out_cos, ec);
      @(negedge clk);
      check("R7 one beat", out_valid, 0);
      check("R7 hold sin", out_sin, es);
    end

    // R8: controls change while a sample is in flight
    v = '{16'sd500, 16'sd600, 1'b0, 1'b0, 1'b0, 2'd0, 16'd0, 16'd0, 16'd0, 16'd16384, 16'd16384, 16'd0};
    @(negedge clk);
    apply(v);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    man_gain_sin = 16'd0; man_gain_cos = 16'd0; man_phase = 16'd16384;
    @(negedge clk);
    check("R8 sin", out_sin, 500);
    check("R8 cos", out_cos, 600);

    // R7: back-to-back stream, one result per cycle
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      v = '{16'(k * 1000 + 100), -16'(k * 500), 1'b1, 1'b1, 1'b1, 2'd1,
            16'd30000, 16'd24000, 16'(k * 2000), 16'd0, 16'd0, 16'd0};
      apply(v);
      in_valid = 1'b1;
      @(negedge clk);
      if (k >= 1) begin
        check("R7 stream valid", out_valid, 1);
        v.s = 16'((k - 1) * 1000 + 100); v.c = -16'((k - 1) * 500); v.eph = 16'((k - 1) * 2000);
        model(v, es, ec);
        check("R3 stream sin", out_sin, es);
        check("R5 stream cos", out_cos, ec);
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    v = '{16'sd3100, -16'sd1500, 1'b1, 1'b1, 1'b1, 2'd1, 16'd30000, 16'd24000, 16'd6000, 16'd0, 16'd0, 16'd0};
    model(v, es, ec);
    check("R7 stream last", out_valid, 1);
    check("R5 stream last cos", out_cos, ec);
    @(negedge clk);
    check("R7 stream end", out_valid, 0);

    finish_run();
  end

endmodule